// File: doc/BRIEF.md
# Serial Channel Register Port

This unit is the host-facing register access logic for one channel of a serial communications controller. The host sees only two byte-wide locations: a control location and a data location. A control write in the idle phase either selects one of sixteen internal registers or, when its upper nibble is nonzero, counts as a command to register 0. The next control access then reaches the selected register, and the selection falls back to zero afterwards. Reading the control location with nothing selected returns the status byte.

The unit keeps the channel's write registers and presents them on a configuration bus for the serial datapath next to it. It builds the read registers from stored values, status inputs and a small receive queue. Writes to register 9 decode a reset of this channel alone or a full hardware reset. A character written for transmission is handed out on a one-cycle strobe. The transmit buffer then stays busy for a fixed number of cycles that stands for one character time.

Top module: `chan_regport`

## Requirements
- R1: In the idle phase, a control write whose bits 7:4 are zero loads bits 3:0 into the pointer and arms it. The next control read or write then targets register number = pointer.
- R2: After the armed access, the pointer goes back to 0 and the unit is idle again. Every control read disarms the pointer. An idle control write with any of bits 7:4 set is a register 0 command: it does not arm the pointer and it changes no register.
- R3: Control reads decode the pointer as follows. Pointers 9 and 13 return register 13, 11 and 15 return register 15, 12 returns register 12, and 10 and 14 return 0x00. Pointers 0 and 4 return the status byte.
- R4: Layout of the status byte: bit 0 = receive queue not empty, bit 1 = zero_cnt input, bit 2 = transmit buffer empty, bit 3 = carrier input, bits 6:5 = 1, bits 7 and 4 = 0.
- R5: Pointers 1 and 5 always read 0x07. Pointers 2 and 6 read register 2. Pointers 3 and 7 read 0x00.
- R6: Received characters enter a queue of QDEPTH (3) entries in arrival order. A push into a full queue is lost. A read of the data location, or a control read at pointer 8, returns the oldest entry and removes it. An empty queue reads 0x00.
- R7: A control write to pointer n (n other than 0, 8 and 9) stores the byte, and cfg_bus[8n+7:8n] shows it. Bytes 0, 8 and 9 of cfg_bus stay 0x00.
- R8: A register 9 write with this channel's bit set (bit 7 when CHAN_A=1, bit 6 otherwise) resets the channel. Register 15 becomes 0xF8. Register 4 gets bit 2 set. Registers 3 and 1 lose bit 0. Register 14 keeps only bits 1:0. Register 10 becomes 0. Register 5 is ANDed with 0x65. The receive queue is flushed and the transmit buffer is marked empty. Registers 2, 11, 12 and 13 keep their values.
- R9: A register 9 write with bits 7:6 = 11, and also rst_n low, gives the hardware reset state. Register 4 = 0x04, register 11 = 0x08, register 15 = 0xF8, and every other write register = 0x00.
- R10: A data write, or a control write at pointer 8, while the transmit buffer is empty pulses tx_strobe for one cycle with tx_char holding the byte, starting the cycle after the write. Status bit 2 then stays low for TX_CYCLES cycles. A data write while the buffer is busy is dropped and produces no strobe.
- R11: A register 9 write that sets only the other channel's reset bit changes nothing in this channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control location |
| ctl_rd | input | 1 | Read strobe for the control location |
| data_wr | input | 1 | Write strobe for the data location |
| data_rd | input | 1 | Read strobe for the data location |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, combinational for the current access |
| rx_push | input | 1 | Received character valid |
| rx_char | input | 8 | Received character |
| carrier | input | 1 | Carrier detect level |
| zero_cnt | input | 1 | Baud counter zero-count flag |
| tx_strobe | output | 1 | One-cycle transmit character strobe |
| tx_char | output | 8 | Character handed to the transmitter |
| cfg_bus | output | 128 | Write registers 0 to 15, one byte each |

## Verification
Read data is combinational, so the value of a read is due in the same cycle as the strobe. The bench drives each access at a falling edge and samples rdata one nanosecond later, before the clock edge that applies any pop or pointer clear. Register stores, resets and the transmit strobe all take effect on the next rising edge, and the bench checks them at the following falling edge. Status bit 2 is expected low at the falling edge after the (TX_CYCLES-1)th edge following the accepting write and high one edge later. The bench times its reads to land on exactly those two cycles.

// File: rtl/chan_regport.sv
module chan_regport #(
  parameter bit CHAN_A    = 1'b1,
  parameter int QDEPTH    = 3,
  parameter int TX_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic         ctl_rd,
  input  logic         data_wr,
  input  logic         data_rd,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic         rx_push,
  input  logic [7:0]   rx_char,
  input  logic         carrier,
  input  logic         zero_cnt,
  output logic         tx_strobe,
  output logic [7:0]   tx_char,
  output logic [127:0] cfg_bus
);
  localparam int CW   = $clog2(QDEPTH + 1);
  localparam int TCW  = $clog2(TX_CYCLES);
  localparam int NREG = 16;

  logic [3:0]     ptr;
  logic           armed;
  logic [7:0]     regs [NREG];
  logic [7:0]     q [QDEPTH];
  logic [CW-1:0]  qcnt;
  logic           tx_empty;
  logic [TCW-1:0] tcnt;

  function automatic logic [7:0] hard_val(input int n);
    case (n)
      4:       return 8'h04;
      11:      return 8'h08;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  wire [3:0]    sel      = armed ? ptr : 4'd0;
  wire          wr_hit   = ctl_wr & armed;
  wire          take_ptr = ctl_wr & ~armed & (wdata[7:4] == 4'd0);
  wire          do_tx    = (data_wr | (wr_hit & (ptr == 4'd8))) & tx_empty;
  wire          q_has    = (qcnt != '0);
  wire          pop      = (data_rd | (ctl_rd & (sel == 4'd8))) & q_has;
  wire [CW-1:0] widx     = qcnt - CW'(pop);
  wire          do_push  = rx_push & (widx < CW'(QDEPTH));
  wire          r9       = wr_hit & (ptr == 4'd9);
  wire          hard_rst = r9 & (wdata[7:6] == 2'b11);
  wire          chan_rst = r9 & (CHAN_A ? wdata[7] : wdata[6]);
  wire          storable = !(ptr == 4'd0 || ptr == 4'd8 || ptr == 4'd9);
  wire [7:0]    head     = q_has ? q[0] : 8'h00;
  wire [7:0]    status   = {1'b0, 2'b11, 1'b0, carrier, tx_empty, zero_cnt, q_has};

  always_comb begin
    if (data_rd) rdata = head;
    else begin
      case (sel)
        4'd0, 4'd4:   rdata = status;
        4'd1, 4'd5:   rdata = 8'h07;
        4'd2, 4'd6:   rdata = regs[2];
        4'd8:         rdata = head;
        4'd9, 4'd13:  rdata = regs[13];
        4'd11, 4'd15: rdata = regs[15];
        4'd12:        rdata = regs[12];
        default:      rdata = 8'h00;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    assign cfg_bus[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      armed     <= 1'b0;
      qcnt      <= '0;
      tx_empty  <= 1'b1;
      tcnt      <= '0;
      tx_strobe <= 1'b0;
      tx_char   <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= hard_val(i);
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
    end else begin
      tx_strobe <= do_tx;
      if (ctl_rd || wr_hit) begin
        ptr   <= '0;
        armed <= 1'b0;
      end else if (take_ptr) begin
        ptr   <= wdata[3:0];
        armed <= 1'b1;
      end
      if (wr_hit && storable) regs[ptr] <= wdata;

      if (do_tx) begin
        tx_char  <= wdata;
        tx_empty <= 1'b0;
        tcnt     <= TCW'(TX_CYCLES - 1);
      end else if (!tx_empty) begin
        if (tcnt == '0) tx_empty <= 1'b1;
        else            tcnt     <= tcnt - 1'b1;
      end

      if (pop)
        for (int i = 0; i < QDEPTH - 1; i++) q[i] <= q[i+1];
      if (do_push) q[widx] <= rx_char;
      qcnt <= qcnt - CW'(pop) + CW'(do_push);

      if (chan_rst) begin
        tx_empty  <= 1'b1;
        qcnt      <= '0;
        regs[15]  <= 8'hF8;
        regs[14]  <= regs[14] & 8'h03;
        regs[10]  <= 8'h00;
        regs[5]   <= regs[5] & 8'h65;
        regs[4]   <= regs[4] | 8'h04;
        regs[3]   <= regs[3] & 8'hFE;
        regs[1]   <= regs[1] & 8'hFE;
      end
      if (hard_rst)
        for (int i = 0; i < NREG; i++) regs[i] <= hard_val(i);
    end
  end
endmodule

module chan_regport_chk #(
  parameter bit CHAN_A = 1'b1,
  parameter int CW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic          ctl_rd,
  input logic          data_wr,
  input logic          data_rd,
  input logic          rx_push,
  input logic [7:0]    wdata,
  input logic          armed,
  input logic [3:0]    ptr,
  input logic          tx_empty,
  input logic          tx_strobe,
  input logic [CW-1:0] qcnt,
  input logic [127:0]  cfg_bus
);
  // R1
  ptr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !armed && wdata[7:4] == 4'd0) |=> (armed && ptr == $past(wdata[3:0])));
  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> !armed);
  // R6
  q_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && qcnt != '0 && !rx_push && !ctl_wr) |=> (qcnt == $past(qcnt) - 1'b1));
  // R8
  chan_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && armed && ptr == 4'd9 && (CHAN_A ? wdata[7] : wdata[6]))
      |=> (tx_empty && qcnt == '0 && cfg_bus[127:120] == 8'hF8));
  // R10
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_empty) |=> (tx_strobe && !tx_empty));
  // R10
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |=> !tx_strobe);
endmodule

bind chan_regport chan_regport_chk #(.CHAN_A(CHAN_A), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .data_wr(data_wr), .data_rd(data_rd), .rx_push(rx_push), .wdata(wdata),
  .armed(armed), .ptr(ptr), .tx_empty(tx_empty), .tx_strobe(tx_strobe),
  .qcnt(qcnt), .cfg_bus(cfg_bus)
);

// File: tb/chan_regport_tb.sv
module chan_regport_tb_top;
  localparam int NT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_rd = 0, data_wr = 0, data_rd = 0, rx_push = 0;
  logic carrier = 0, zero_cnt = 0;
  logic [7:0] wdata = 0, rx_char = 0;
  logic [7:0] rdata, tx_char;
  logic tx_strobe;
  logic [127:0] cfg_bus;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chan_regport #(.CHAN_A(1'b1), .QDEPTH(3), .TX_CYCLES(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata),
    .rx_push(rx_push), .rx_char(rx_char), .carrier(carrier), .zero_cnt(zero_cnt),
    .tx_strobe(tx_strobe), .tx_char(tx_char), .cfg_bus(cfg_bus));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] cb(input int n);
    return cfg_bus[8*n +: 8];
  endfunction

  task automatic cw(input logic [7:0] v);
    ctl_wr = 1; wdata = v; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic cr(output logic [7:0] v);
    ctl_rd = 1; #1 v = rdata; @(negedge clk); ctl_rd = 0;
  endtask
  task automatic dw(input logic [7:0] v);
    data_wr = 1; wdata = v; @(negedge clk); data_wr = 0;
  endtask
  task automatic dr(output logic [7:0] v);
    data_rd = 1; #1 v = rdata; @(negedge clk); data_rd = 0;
  endtask
  task automatic push(input logic [7:0] v);
    rx_push = 1; rx_char = v; @(negedge clk); rx_push = 0;
  endtask
  task automatic wreg(input logic [3:0] n, input logic [7:0] v);
    cw({4'd0, n}); cw(v);
  endtask
  task automatic rreg(input logic [3:0] n, output logic [7:0] v);
    cw({4'd0, n}); cr(v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cr(v); chk("R9 reset status", v, 8'h64);
    chk("R9 reset reg4", cb(4), 8'h04);
    chk("R9 reset reg11", cb(11), 8'h08);
    chk("R9 reset reg15", cb(15), 8'hF8);
    chk("R9 reset reg12", cb(12), 8'h00);
    chk("R10 no strobe at reset", {7'd0, tx_strobe}, 8'h00);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    wreg(12, 8'h5A);
    chk("R7 reg12 stored", cb(12), 8'h5A);
    cr(v); chk("R2 idle after write", v, 8'h64);
    rreg(12, v); chk("R1 armed read reg12", v, 8'h5A);
    cr(v); chk("R2 idle after read", v, 8'h64);
    cw(8'h38);
    cr(v); chk("R2 command does not arm", v, 8'h64);
    chk("R2 command keeps reg12", cb(12), 8'h5A);
    chk("R7 slot8 zero", cb(8), 8'h00);
  endtask

  task automatic t_alias;
    logic [7:0] v;
    wreg(13, 8'h33); wreg(15, 8'h81); wreg(2, 8'h9C); wreg(14, 8'h03);
    rreg(9, v);  chk("R3 ptr9", v, 8'h33);
    rreg(13, v); chk("R3 ptr13", v, 8'h33);
    rreg(11, v); chk("R3 ptr11", v, 8'h81);
    rreg(15, v); chk("R3 ptr15", v, 8'h81);
    rreg(10, v); chk("R3 ptr10", v, 8'h00);
    rreg(14, v); chk("R3 ptr14", v, 8'h00);
    rreg(4, v);  chk("R3 ptr4 status", v, 8'h64);
    rreg(1, v);  chk("R5 ptr1", v, 8'h07);
    rreg(5, v);  chk("R5 ptr5", v, 8'h07);
    rreg(2, v);  chk("R5 ptr2", v, 8'h9C);
    rreg(6, v);  chk("R5 ptr6", v, 8'h9C);
    rreg(3, v);  chk("R5 ptr3", v, 8'h00);
    rreg(7, v);  chk("R5 ptr7", v, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    carrier = 1; zero_cnt = 1;
    cr(v); chk("R4 carrier zc", v, 8'h6E);
    push(8'hEE);
    cr(v); chk("R4 rx avail", v, 8'h6F);
    carrier = 0; zero_cnt = 0;
    dr(v); chk("R6 pop single", v, 8'hEE);
    cr(v); chk("R4 back to idle", v, 8'h64);
  endtask

  task automatic t_queue;
    logic [7:0] v;
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    dr(v); chk("R6 oldest first", v, 8'hA1);
    dr(v); chk("R6 second", v, 8'hA2);
    push(8'hB1);
    dr(v); chk("R6 third", v, 8'hA3);
    dr(v); chk("R6 full push dropped", v, 8'hB1);
    dr(v); chk("R6 empty reads zero", v, 8'h00);
    push(8'hC1);
    rreg(8, v); chk("R6 ptr8 pop", v, 8'hC1);
    cr(v); chk("R6 queue drained", v, 8'h64);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    dw(8'h41);
    chk("R10 strobe", {7'd0, tx_strobe}, 8'h01);
    chk("R10 char", tx_char, 8'h41);
    dw(8'h42);
    chk("R10 busy write dropped", {7'd0, tx_strobe}, 8'h00);
    repeat (NT - 2) @(negedge clk);
    cr(v); chk("R10 still busy", v, 8'h60);
    cr(v); chk("R10 empty after char time", v, 8'h64);
    wreg(8, 8'h55);
    chk("R10 ptr8 strobe", {7'd0, tx_strobe}, 8'h01);
    chk("R10 ptr8 char", tx_char, 8'h55);
    chk("R7 ptr8 not stored", cb(8), 8'h00);
    repeat (NT) @(negedge clk);
  endtask

  task automatic t_chanreset;
    logic [7:0] v;
    wreg(1, 8'hFF); wreg(3, 8'hFF); wreg(5, 8'hFF); wreg(10, 8'hFF);
    wreg(14, 8'hFF); wreg(4, 8'h40); wreg(12, 8'h12); wreg(13, 8'h34);
    wreg(2, 8'h56); wreg(11, 8'h77); wreg(15, 8'h00);
    push(8'h01); push(8'h02); dw(8'h99);
    wreg(9, 8'h80);
    chk("R8 reg1", cb(1), 8'hFE);
    chk("R8 reg3", cb(3), 8'hFE);
    chk("R8 reg5", cb(5), 8'h65);
    chk("R8 reg10", cb(10), 8'h00);
    chk("R8 reg14", cb(14), 8'h03);
    chk("R8 reg4", cb(4), 8'h44);
    chk("R8 reg15", cb(15), 8'hF8);
    chk("R8 reg12 kept", cb(12), 8'h12);
    chk("R8 reg13 kept", cb(13), 8'h34);
    chk("R8 reg2 kept", cb(2), 8'h56);
    chk("R8 reg11 kept", cb(11), 8'h77);
    chk("R7 slot9 zero", cb(9), 8'h00);
    cr(v); chk("R8 queue flushed tx empty", v, 8'h64);
  endtask

  task automatic t_other;
    wreg(15, 8'h11);
    wreg(9, 8'h40);
    chk("R11 reg15 unchanged", cb(15), 8'h11);
    chk("R11 reg12 unchanged", cb(12), 8'h12);
    chk("R11 reg1 unchanged", cb(1), 8'hFE);
  endtask

  task automatic t_hard;
    logic [7:0] v;
    wreg(9, 8'hC0);
    for (int n = 1; n < 16; n++) begin
      logic [7:0] e;
      e = (n == 4) ? 8'h04 : (n == 11) ? 8'h08 : (n == 15) ? 8'hF8 : 8'h00;
      chk($sformatf("R9 hard reg%0d", n), cb(n), e);
    end
    cr(v); chk("R9 hard status", v, 8'h64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_alias();
    t_status();
    t_queue();
    t_tx();
    t_chanreset();
    t_other();
    t_hard();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule